// File: doc/BRIEF.md
# Counted-Transfer SPI Master

This block is a serial peripheral interface master whose exchanges are framed by a programmable transfer count and a per-transfer bit width, not by a fixed byte length. Software loads a count of transfers. It pushes transmit words through a write port into a two-entry transmit queue and pulls received words from a two-entry receive queue through a read port. Neither queue can be addressed directly.

Each transfer shifts out the low `width` bits of one transmit word, most significant of those bits first. At the same time it gathers the same number of bits from the slave into the low bits of a receive word. A transfer starts only while the count is nonzero and a transmit word is waiting. Each completed transfer lowers the count by one. When the count reaches zero, the slave select is released and a done flag rises. Sticky flags report a transmit write made while the queue was full and a received word dropped because the receive queue was full.

The serial clock idle level comes from the polarity input. Each half period of the serial clock lasts `div+1` system clocks. Data is driven on the idle-to-active edge and sampled on the active-to-idle edge.

Top module: `spi_cnt_master`

## Requirements
- R1: After reset: `ss_n`=1, `done`=0, `tx_werr`=0, `rx_ovr`=0, `rx_avail`=0, `tx_full`=0, `xfer_left`=0, `sclk`=0.
- R2: A transfer starts only when `xfer_left` is nonzero and the transmit queue holds a word. Each completed transfer lowers `xfer_left` by one. A count of zero leaves the bus idle and the queued words untouched.
- R3: `width_code`=0 selects 8 bits per transfer, and `width_code`=n (1..7) selects n bits. The transmitted bits are bits n-1 down to 0 of the queued word, in that order. Higher bits are not sent.
- R4: Received bits arrive first-bit-most-significant in the low n bits of the receive word. The upper bits are 0.
- R5: `sclk` settles at `cpol` when no transfer runs. During a transfer, each `sclk` level lasts `div+1` clock cycles, so an n-bit transfer spans 2n(div+1) cycles.
- R6: `mosi` changes only on the edge where `sclk` leaves its idle level. `miso` is captured on the edge where `sclk` returns to idle.
- R7: With `ss_en`=1, `ss_n` is 0 from the start of the first transfer after a count load until the transfer that brings the count to zero ends. This holds even while the block waits for transmit data between transfers. With `ss_en`=0, `ss_n` stays 1.
- R8: `done` rises in the cycle after the transfer that brings the count to zero ends. A write to the counter clears it.
- R9: The transmit queue holds two words, and `tx_full` shows when it is full. A write while it is full is discarded and sets the sticky `tx_werr`.
- R10: The receive queue holds two words. `rx_avail` shows that a word is present, and `rx_rd` pops it. A word that completes while the queue is full is dropped and sets the sticky `rx_ovr`.
- R11: A counter write clears `tx_werr` and `rx_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpol | input | 1 | Serial clock idle level |
| ss_en | input | 1 | Let the block drive the slave select |
| div | input | 8 | Half-period length minus one, in clock cycles |
| width_code | input | 3 | Bits per transfer (0 means 8) |
| cnt_wr | input | 1 | Load the transfer counter |
| cnt_wdata | input | 8 | Value for the transfer counter |
| xfer_left | output | 8 | Transfers still to run |
| tx_wr | input | 1 | Push one word into the transmit queue |
| tx_wdata | input | 8 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_werr | output | 1 | Sticky: write rejected on a full queue |
| rx_rd | input | 1 | Pop one word from the receive queue |
| rx_rdata | output | 8 | Oldest received word |
| rx_avail | output | 1 | Receive queue holds a word |
| rx_ovr | output | 1 | Sticky: received word dropped |
| done | output | 1 | Count has reached zero |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Slave select, active low |

## Verification
The bench builds the block with its default parameters: 8-bit words, an 8-bit counter and an 8-bit divider. It sets the divider to 0, 1 and 3 at run time, which covers both the back-to-back tick case and longer half periods. Full 8-bit widths and partial 3-bit and 5-bit widths are run with both clock polarities. The slave side is driven three ways: a pseudo-random bit stream, a constant one, and a loopback of `mosi`. The loopback lets the received words be predicted exactly. A two-entry queue depth makes both full-queue cases easy to reach: a third transmit write while the count is zero, and a third completed transfer with no reads.

// File: rtl/spi_cnt_pkg.sv
package spi_cnt_pkg;

  // Effective bits per transfer: code 0 selects a full word.
  function automatic int unsigned width_decode(input int unsigned code,
                                               input int unsigned full);
    return (code == 0) ? full : code;
  endfunction

  // Serial clock level for the idle or active half of a bit.
  function automatic logic sclk_level(input logic pol, input logic active);
    return active ? ~pol : pol;
  endfunction

endpackage

// File: rtl/spi_cnt_fifo.sv
module spi_cnt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         push_rej
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign push_rej = push && full;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/spi_cnt_engine.sv
module spi_cnt_engine
  import spi_cnt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int WID_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [WID_W-1:0]  width_code,
  input  logic [DIV_W-1:0]  div,
  input  logic              cpol,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  logic [DIV_W-1:0]  hcnt;
  logic              half_q;
  logic [BIT_W-1:0]  bits_left;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              busy_q, sclk_q, mosi_q;
  logic [BIT_W-1:0]  w_eff;
  logic              tick, lead_tick, trail_tick;

  function automatic logic [DATA_W-1:0] align_left(input logic [DATA_W-1:0] d,
                                                   input logic [BIT_W-1:0] w);
    return d << (DATA_W - int'(w));
  endfunction

  assign w_eff      = BIT_W'(width_decode(int'(width_code), DATA_W));
  assign tick       = busy_q && (hcnt == div);
  assign lead_tick  = tick && !half_q;
  assign trail_tick = tick && half_q;
  assign xfer_done  = trail_tick && (bits_left == BIT_W'(1));
  assign rx_word    = {rx_sh[DATA_W-2:0], miso};
  assign busy       = busy_q;
  assign sclk       = sclk_q;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      hcnt      <= '0;
      half_q    <= 1'b0;
      bits_left <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk_q    <= 1'b0;
      mosi_q    <= 1'b0;
    end else if (!busy_q) begin
      sclk_q <= sclk_level(cpol, 1'b0);
      if (start) begin
        busy_q    <= 1'b1;
        hcnt      <= '0;
        half_q    <= 1'b0;
        bits_left <= w_eff;
        tx_sh     <= align_left(tx_word, w_eff);
        rx_sh     <= '0;
      end
    end else if (lead_tick) begin
      hcnt   <= '0;
      sclk_q <= sclk_level(cpol, 1'b1);
      mosi_q <= tx_sh[DATA_W-1];
      tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
      half_q <= 1'b1;
    end else if (trail_tick) begin
      hcnt      <= '0;
      sclk_q    <= sclk_level(cpol, 1'b0);
      rx_sh     <= rx_word;
      half_q    <= 1'b0;
      bits_left <= bits_left - BIT_W'(1);
      if (bits_left == BIT_W'(1)) busy_q <= 1'b0;
    end else begin
      hcnt <= hcnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_cnt_master.sv
module spi_cnt_master #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int WID_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              ss_en,
  input  logic [DIV_W-1:0]  div,
  input  logic [WID_W-1:0]  width_code,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  xfer_left,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              tx_full,
  output logic              tx_werr,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_avail,
  output logic              rx_ovr,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  logic [CNT_W-1:0]  cnt_q;
  logic              frame_q, done_q, werr_q, ovr_q;
  logic              busy, start, xfer_done;
  logic              tx_empty, rx_empty, rx_full;
  logic              tx_push_rej, rx_push_rej;
  logic [DATA_W-1:0] tx_head, rx_word;
  logic              last_xfer;

  assign start     = !busy && (cnt_q != '0) && !tx_empty;
  assign last_xfer = xfer_done && (cnt_q == CNT_W'(1));

  spi_cnt_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr), .push_data(tx_wdata), .pop(start),
    .head(tx_head), .empty(tx_empty), .full(tx_full), .push_rej(tx_push_rej)
  );

  spi_cnt_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(xfer_done), .push_data(rx_word), .pop(rx_rd),
    .head(rx_rdata), .empty(rx_empty), .full(rx_full), .push_rej(rx_push_rej)
  );

  spi_cnt_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WID_W(WID_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_head),
    .width_code(width_code), .div(div), .cpol(cpol), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy), .xfer_done(xfer_done),
    .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      frame_q <= 1'b0;
      done_q  <= 1'b0;
      werr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (cnt_wr)                         cnt_q <= cnt_wdata;
      else if (xfer_done && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);

      if (start)                          frame_q <= 1'b1;
      else if (last_xfer && !cnt_wr)      frame_q <= 1'b0;

      if (cnt_wr)                         done_q <= 1'b0;
      else if (last_xfer)                 done_q <= 1'b1;

      if (tx_push_rej)                    werr_q <= 1'b1;
      else if (cnt_wr)                    werr_q <= 1'b0;

      if (rx_push_rej)                    ovr_q <= 1'b1;
      else if (cnt_wr)                    ovr_q <= 1'b0;
    end
  end

  assign xfer_left = cnt_q;
  assign done      = done_q;
  assign tx_werr   = werr_q;
  assign rx_ovr    = ovr_q;
  assign rx_avail  = !rx_empty;
  assign ss_n      = !(ss_en && frame_q);
endmodule

// File: rtl/spi_cnt_master_chk.sv
module spi_cnt_master_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpol,
  input logic             ss_en,
  input logic             cnt_wr,
  input logic             sclk,
  input logic             ss_n,
  input logic             done,
  input logic             tx_werr,
  input logic             rx_ovr,
  input logic [CNT_W-1:0] xfer_left,
  input logic             busy,
  input logic             start,
  input logic             xfer_done,
  input logic             tx_push_rej,
  input logic             rx_full
);
  // R5: clock rests at the polarity level between transfers
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy && $past(!busy)) |-> (sclk == $past(cpol)));

  // R7: select held low while shifting
  p_ss_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ss_en) |-> !ss_n);

  // R2: no transfer begins on a zero count
  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_left == '0) |-> !start);

  // R2: each completion lowers the count by one
  p_cnt_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cnt_wr && xfer_left != '0) |=> (xfer_left == $past(xfer_left) - CNT_W'(1)));

  // R8: done follows the final completion
  p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cnt_wr && xfer_left == CNT_W'(1)) |=> (done && !ss_n == 1'b0));

  // R8: counter write clears done
  p_done_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !done);

  // R9: rejected write raises the sticky flag
  p_werr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_rej |=> tx_werr);

  // R10: completion into a full receive queue raises overrun
  p_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && rx_full) |=> rx_ovr);

  // R11: counter write clears the sticky error when nothing re-sets it
  p_werr_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !tx_push_rej) |=> !tx_werr);
endmodule

bind spi_cnt_master spi_cnt_master_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .ss_en(ss_en), .cnt_wr(cnt_wr),
  .sclk(sclk), .ss_n(ss_n), .done(done), .tx_werr(tx_werr), .rx_ovr(rx_ovr),
  .xfer_left(xfer_left), .busy(busy), .start(start), .xfer_done(xfer_done),
  .tx_push_rej(tx_push_rej), .rx_full(rx_full)
);

// File: tb/spi_cnt_master_test.sv
module spi_cnt_master_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       cpol = 0, ss_en = 1;
  logic [7:0] div = 8'd1;
  logic [2:0] width_code = 3'd0;
  logic       cnt_wr = 0;
  logic [7:0] cnt_wdata = 0;
  logic [7:0] xfer_left;
  logic       tx_wr = 0;
  logic [7:0] tx_wdata = 0;
  logic       tx_full, tx_werr;
  logic       rx_rd = 0;
  logic [7:0] rx_rdata;
  logic       rx_avail, rx_ovr, done, sclk, mosi, ss_n;
  logic       miso = 0;

  int n_run = 0, n_fail = 0;
  int miso_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cnt_master uut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .ss_en(ss_en), .div(div),
    .width_code(width_code), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .xfer_left(xfer_left), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .tx_full(tx_full), .tx_werr(tx_werr), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .rx_avail(rx_avail), .rx_ovr(rx_ovr), .done(done), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  // slave side: random stream, constant one, or loopback
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (miso_mode)
      0: miso <= lfsr[0];
      1: miso <= 1'b1;
      default: miso <= mosi;
    endcase
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int   m_txq[$], m_rxq[$];
  int   m_cnt, m_hc, m_half, m_w, m_tx, m_rx, m_bit;
  bit   m_busy, m_frame, m_done, m_werr, m_ovr, m_sclk, m_mosi;

  always @(posedge clk or negedge rst_n) begin
    int txn, rxn;
    bit st, fin;
    if (!rst_n) begin
      m_txq.delete(); m_rxq.delete();
      m_cnt = 0; m_hc = 0; m_half = 0; m_w = 8; m_tx = 0; m_rx = 0; m_bit = 0;
      m_busy = 0; m_frame = 0; m_done = 0; m_werr = 0; m_ovr = 0;
      m_sclk = 0; m_mosi = 0;
    end else begin
      txn = m_txq.size();
      rxn = m_rxq.size();
      st  = !m_busy && m_cnt != 0 && txn > 0;
      fin = 0;
      if (!m_busy) begin
        m_sclk = cpol;
        if (st) begin
          m_busy = 1; m_hc = 0; m_half = 0;
          m_w = (width_code == 0) ? 8 : int'(width_code);
          m_tx = m_txq.pop_front(); m_rx = 0; m_bit = m_w - 1;
          m_frame = 1;
        end
      end else if (m_hc == int'(div)) begin
        m_hc = 0;
        if (m_half == 0) begin
          m_sclk = !cpol; m_mosi = (m_tx >> m_bit) & 1; m_half = 1;
        end else begin
          m_sclk = cpol; m_rx = (m_rx << 1) | int'(miso); m_half = 0;
          if (m_bit == 0) begin m_busy = 0; fin = 1; end
          else m_bit--;
        end
      end else m_hc++;

      if (cnt_wr) begin
        m_cnt = cnt_wdata; m_done = 0; m_werr = 0; m_ovr = 0;
      end else if (fin && m_cnt != 0) begin
        if (m_cnt == 1) begin m_done = 1; m_frame = 0; end
        m_cnt--;
      end
      if (tx_wr) begin
        if (txn >= 2) m_werr = 1; else m_txq.push_back(int'(tx_wdata));
      end
      if (rx_rd && rxn > 0) void'(m_rxq.pop_front());
      if (fin) begin
        if (rxn >= 2) m_ovr = 1; else m_rxq.push_back(m_rx & 8'hFF);
      end
    end
  end

  always begin
    @(negedge clk); #1;
    if (rst_n && cmp_en) begin
      chk("R5 sclk", sclk, m_sclk);
      chk("R3/R6 mosi", mosi, m_mosi);
      chk("R7 ss_n", ss_n, !(ss_en && m_frame));
      chk("R8 done", done, m_done);
      chk("R9 tx_werr", tx_werr, m_werr);
      chk("R9 tx_full", tx_full, m_txq.size() == 2);
      chk("R10 rx_ovr", rx_ovr, m_ovr);
      chk("R10 rx_avail", rx_avail, m_rxq.size() > 0);
      chk("R2 xfer_left", xfer_left, m_cnt);
      if (m_rxq.size() > 0) chk("R4 rx_rdata", rx_rdata, m_rxq[0]);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_cnt(input int v);
    cnt_wr = 1; cnt_wdata = 8'(v); @(negedge clk); cnt_wr = 0;
  endtask
  task automatic wr_tx(input int v);
    tx_wr = 1; tx_wdata = 8'(v); @(negedge clk); tx_wr = 0;
  endtask
  task automatic rd_rx();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask
  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hi;
    step(3);
    rst_n = 1;
    cmp_en = 1;
    step(1);
    // R1 reset state
    chk("R1 ss_n", ss_n, 1); chk("R1 done", done, 0);
    chk("R1 tx_werr", tx_werr, 0); chk("R1 rx_ovr", rx_ovr, 0);
    chk("R1 rx_avail", rx_avail, 0); chk("R1 tx_full", tx_full, 0);
    chk("R1 xfer_left", xfer_left, 0); chk("R1 sclk", sclk, 0);

    // full-byte loopback, two transfers
    miso_mode = 2; div = 8'd1; width_code = 3'd0;
    wr_tx(8'hA5); wr_tx(8'h3C); wr_cnt(2);
    wait_done();
    chk("R8 done after count", done, 1);
    chk("R2 count zero", xfer_left, 0);
    chk("R7 ss released", ss_n, 1);
    chk("R4 loopback first", rx_rdata, 8'hA5); rd_rx();
    chk("R4 loopback second", rx_rdata, 8'h3C); rd_rx();

    // 3-bit transfer, idle-high clock, slave drives ones
    cpol = 1; div = 8'd0; width_code = 3'd3; miso_mode = 1;
    step(2);
    chk("R5 idle high", sclk, 1);
    wr_tx(8'h05); wr_cnt(1);
    wait_done();
    chk("R4 partial upper zero", rx_rdata, 8'h07); rd_rx();

    // 5-bit loopback: upper bits not sent
    miso_mode = 2; width_code = 3'd5;
    wr_tx(8'hF3); wr_cnt(1);
    wait_done();
    chk("R3 low bits only", rx_rdata, 8'h13); rd_rx();

    // transmit overflow with a zero count
    cpol = 0; width_code = 3'd0; div = 8'd1;
    wr_cnt(0);
    wr_tx(8'h11); wr_tx(8'h22); wr_tx(8'h33);
    chk("R9 werr set", tx_werr, 1);
    chk("R9 full", tx_full, 1);
    step(20);
    chk("R2 idle at zero", xfer_left, 0);
    chk("R2 no receive at zero", rx_avail, 0);
    chk("R2 queue kept", tx_full, 1);
    wr_cnt(2);
    chk("R11 werr cleared", tx_werr, 0);
    wait_done();
    chk("R9 first kept", rx_rdata, 8'h11); rd_rx();
    chk("R9 second kept", rx_rdata, 8'h22); rd_rx();
    chk("R9 third discarded", rx_avail, 0);
    chk("R9 queue drained", tx_full, 0);

    // receive overrun
    wr_tx(8'h41); wr_tx(8'h42); wr_cnt(3);
    while (tx_full) @(negedge clk);
    wr_tx(8'h43);
    wait_done();
    chk("R10 overrun", rx_ovr, 1);
    chk("R10 oldest", rx_rdata, 8'h41); rd_rx();
    chk("R10 next", rx_rdata, 8'h42); rd_rx();
    chk("R10 newest dropped", rx_avail, 0);
    wr_cnt(0);
    chk("R11 ovr cleared", rx_ovr, 0);
    chk("R8 done cleared", done, 0);

    // select disabled, half-period length
    ss_en = 0; div = 8'd3; miso_mode = 0;
    wr_tx(8'h5A); wr_cnt(1);
    while (sclk == 0) @(negedge clk);
    chk("R7 ss held high", ss_n, 1);
    hi = 0;
    while (sclk == 1) begin hi++; @(negedge clk); end
    chk("R5 half period", hi, 4);
    wait_done();
    rd_rx();

    // select held across a gap in transmit data
    ss_en = 1; div = 8'd0;
    wr_tx(8'h01); wr_cnt(2);
    while (xfer_left != 1) @(negedge clk);
    step(3);
    chk("R7 ss held in gap", ss_n, 0);
    chk("R8 not yet done", done, 0);
    wr_tx(8'h02);
    wait_done();
    chk("R7 ss after last", ss_n, 1);

    step(5);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule